// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Word Link

This block carries a multi-bit binary word across a dual-rail, return-to-zero channel that uses a four-phase acknowledge. Every logical bit travels on its own pair of wires. A pair at rest carries no data. A pair that holds data shows exactly one rail high, so the data code itself tells whether the data is present. The receiver therefore finds the end of a transfer by looking at the bits, with no separate strobe wire.

The sending half accepts a binary word with a one-cycle start pulse. It drives a valid codeword on all pairs and holds it until the acknowledge rises. It then returns every pair to rest and waits for the acknowledge to fall before the next word may leave. A start that arrives while a transfer is in progress is held in a single pending slot. The receiving half checks that every pair is valid before it captures and decodes the word and raises the acknowledge. It lowers the acknowledge only once every pair is back at rest. It also flags any pair that shows both rails high.

Both halves run synchronously on one sampling clock. The channel wires are brought out as ports, so the two halves can be joined directly, placed apart, or observed.

Top module: `dr_link`

## Requirements
- R1: Bit i of a word travels on rails [2i+1:2i]. The pair value 2'b01 means logic 0, 2'b10 means logic 1, and 2'b00 is the rest (spacer) value. When the sender accepts a start at a clock edge, it drives the encoded word from that edge on.
- R2: The sender holds the codeword unchanged while the acknowledge is low. After the first edge at which it samples the acknowledge high, it drives all pairs to 2'b00.
- R3: The sender keeps all pairs at 2'b00 until it samples the acknowledge low, and then goes idle. A word is never launched at an edge where the acknowledge is high.
- R4: A start that arrives while the sender is busy is held in one pending slot, and a later start replaces it. The pending word is launched as soon as the sender is idle with the acknowledge low. `snd_busy` is high while a transfer or a pending word exists.
- R5: The receiver raises the acknowledge one cycle after it samples every pair as valid (01 or 10). A partly arrived word never raises it.
- R6: In the cycle the acknowledge rises, `rcv_word` holds the decoded word (bit i = rail 2i+1) and `rcv_strobe` is high for exactly that one cycle.
- R7: The receiver lowers the acknowledge one cycle after it samples every pair at 2'b00. While any pair is non-zero, the acknowledge stays high.
- R8: While `rcv_hold` is high, the acknowledge does not change in either direction.
- R9: If any pair shows 2'b11, `rcv_err` is high in the following cycle and the acknowledge does not rise on that sample.
- R10: Reset drives all sender rails to 0 and the acknowledge, `snd_busy`, `rcv_strobe` and `rcv_err` low.
- R11: When the two halves are joined, each strobed word equals the word that was started, in the order the words were started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_word | input | W | Binary word to send |
| snd_start | input | 1 | One-cycle request to send `snd_word` |
| snd_busy | output | 1 | Transfer in progress or word pending |
| snd_rails | output | 2W | Dual-rail channel driven by the sender |
| snd_ack | input | 1 | Acknowledge seen by the sender |
| rcv_rails | input | 2W | Dual-rail channel seen by the receiver |
| rcv_hold | input | 1 | Stalls both acknowledge edges |
| rcv_ack | output | 1 | Acknowledge driven by the receiver |
| rcv_word | output | W | Last decoded word |
| rcv_strobe | output | 1 | One-cycle pulse with each captured word |
| rcv_err | output | 1 | A pair showed both rails high in the last sample |

## Verification
The bench feeds the receiver a word that is only partly valid. A design that ANDs too few pairs, or ORs them together, would acknowledge that word early and capture garbage. The bench also clears the pairs one at a time during return-to-zero. A receiver that tests a single bit would drop the acknowledge while data is still on the wires. The bench issues starts while a transfer is in flight, so a sender without a pending slot would lose a word, and one that launches before the acknowledge falls would break the phase order. The bench also injects a 2'b11 pair to confirm that such a word raises the error flag rather than being taken as a valid word.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_DATA = 2'd1,
        SND_RTZ  = 2'd2
    } snd_state_e;

endpackage

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] rails_i,
    output logic           all_valid_o,
    output logic           all_empty_o,
    output logic           any_bad_o,
    output logic [W-1:0]   word_o
);

    logic [W-1:0] pair_has;
    logic [W-1:0] pair_bad;

    generate
        for (genvar i = 0; i < W; i++) begin : g_pair
            assign pair_has[i] = rails_i[2*i+1] | rails_i[2*i];
            assign pair_bad[i] = rails_i[2*i+1] & rails_i[2*i];
            assign word_o[i]   = rails_i[2*i+1];
        end
    endgenerate

    assign all_valid_o = &pair_has;
    assign all_empty_o = ~|pair_has;
    assign any_bad_o   = |pair_bad;

endmodule

// File: rtl/dr_sender.sv
module dr_sender
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   word_i,
    input  logic           start_i,
    input  logic           ack_i,
    output logic [2*W-1:0] rails_o,
    output logic           busy_o
);

    localparam int RW = 2 * W;

    typedef struct packed {
        snd_state_e     st;
        logic [W-1:0]   word;
        logic           pend;
        logic [W-1:0]   pend_word;
        logic [RW-1:0]  rails;
    } snd_regs_t;

    snd_regs_t s_d, s_q;
    logic [RW-1:0] enc_d;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SND_IDLE: begin
                if (!ack_i && s_q.pend) begin
                    s_d.st    = SND_DATA;
                    s_d.word  = s_q.pend_word;
                    s_d.pend  = start_i;
                    if (start_i) s_d.pend_word = word_i;
                end else if (!ack_i && start_i) begin
                    s_d.st   = SND_DATA;
                    s_d.word = word_i;
                end else if (start_i) begin
                    s_d.pend      = 1'b1;
                    s_d.pend_word = word_i;
                end
            end
            SND_DATA: begin
                if (ack_i) s_d.st = SND_RTZ;
                if (start_i) begin
                    s_d.pend      = 1'b1;
                    s_d.pend_word = word_i;
                end
            end
            SND_RTZ: begin
                if (!ack_i) s_d.st = SND_IDLE;
                if (start_i) begin
                    s_d.pend      = 1'b1;
                    s_d.pend_word = word_i;
                end
            end
            default: s_d.st = SND_IDLE;
        endcase
        for (int i = 0; i < W; i++) begin
            enc_d[2*i+1] = s_d.word[i];
            enc_d[2*i]   = ~s_d.word[i];
        end
        s_d.rails = (s_d.st == SND_DATA) ? enc_d : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SND_IDLE, word: '0, pend: 1'b0, pend_word: '0, rails: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rails_o = s_q.rails;
    assign busy_o  = (s_q.st != SND_IDLE) || s_q.pend;

    // codeword held while waiting for the acknowledge
    p_hold_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SND_DATA && !ack_i) |=> $stable(rails_o));

    // spacer follows the acknowledge
    p_spacer_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SND_DATA && ack_i) |=> (rails_o == '0));

    // no launch while the acknowledge is high
    p_launch_ack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SND_DATA) && ack_i |=> (s_q.st != SND_DATA));

    // pending word leaves once idle and acknowledge low
    p_pend_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SND_IDLE && s_q.pend && !ack_i)
        |=> (s_q.st == SND_DATA && s_q.word == $past(s_q.pend_word)));

endmodule

// File: rtl/dr_receiver.sv
module dr_receiver #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] rails_i,
    input  logic           hold_i,
    output logic           ack_o,
    output logic [W-1:0]   word_o,
    output logic           strobe_o,
    output logic           err_o
);

    typedef struct packed {
        logic         ack;
        logic [W-1:0] word;
        logic         strobe;
        logic         err;
    } rcv_regs_t;

    rcv_regs_t r_d, r_q;

    logic         all_valid;
    logic         all_empty;
    logic         any_bad;
    logic [W-1:0] dec_word;

    dr_completion #(.W(W)) u_comp (
        .rails_i     (rails_i),
        .all_valid_o (all_valid),
        .all_empty_o (all_empty),
        .any_bad_o   (any_bad),
        .word_o      (dec_word)
    );

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;
        r_d.err    = any_bad;
        if (!r_q.ack) begin
            if (all_valid && !any_bad && !hold_i) begin
                r_d.ack    = 1'b1;
                r_d.word   = dec_word;
                r_d.strobe = 1'b1;
            end
        end else if (all_empty && !hold_i) begin
            r_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{ack: 1'b0, word: '0, strobe: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o    = r_q.ack;
    assign word_o   = r_q.word;
    assign strobe_o = r_q.strobe;
    assign err_o    = r_q.err;

    p_ack_rise_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(all_valid));

    p_strobe_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $rose(ack_o));

    p_ack_fall_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(all_empty));

    p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(ack_o));

    p_bad_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_bad && !ack_o) |=> (err_o && !ack_o));

endmodule

// File: rtl/dr_link.sv
module dr_link #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   snd_word,
    input  logic           snd_start,
    output logic           snd_busy,
    output logic [2*W-1:0] snd_rails,
    input  logic           snd_ack,
    input  logic [2*W-1:0] rcv_rails,
    input  logic           rcv_hold,
    output logic           rcv_ack,
    output logic [W-1:0]   rcv_word,
    output logic           rcv_strobe,
    output logic           rcv_err
);

    dr_sender #(.W(W)) u_snd (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (snd_word),
        .start_i (snd_start),
        .ack_i   (snd_ack),
        .rails_o (snd_rails),
        .busy_o  (snd_busy)
    );

    dr_receiver #(.W(W)) u_rcv (
        .clk      (clk),
        .rst_n    (rst_n),
        .rails_i  (rcv_rails),
        .hold_i   (rcv_hold),
        .ack_o    (rcv_ack),
        .word_o   (rcv_word),
        .strobe_o (rcv_strobe),
        .err_o    (rcv_err)
    );

endmodule

// File: tb/dr_link_test.sv
module dr_link_test;

    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   snd_word = '0;
    logic           snd_start = 1'b0;
    logic           snd_busy;
    logic [2*W-1:0] snd_rails;
    logic           rcv_hold = 1'b0;
    logic           rcv_ack;
    logic [W-1:0]   rcv_word;
    logic           rcv_strobe;
    logic           rcv_err;
    logic           inj_en = 1'b0;
    logic [2*W-1:0] inj_val = '0;
    logic [2*W-1:0] chan;

    assign chan = inj_en ? inj_val : snd_rails;

    dr_link #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .snd_word(snd_word), .snd_start(snd_start),
        .snd_busy(snd_busy), .snd_rails(snd_rails), .snd_ack(rcv_ack),
        .rcv_rails(chan), .rcv_hold(rcv_hold), .rcv_ack(rcv_ack),
        .rcv_word(rcv_word), .rcv_strobe(rcv_strobe), .rcv_err(rcv_err)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [W-1:0] sent_q[$];

    function automatic logic [2*W-1:0] enc(input logic [W-1:0] w);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) r[2*i +: 2] = w[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference
    int           m_phase = 0;
    logic [W-1:0] m_sword = '0;
    bit           m_pend = 0;
    logic [W-1:0] m_pword = '0;
    logic [2*W-1:0] m_rails = '0;
    bit           m_ack = 0;
    bit           m_strobe = 0;
    bit           m_err = 0;
    logic [W-1:0] m_rword = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pend = 0; m_rails = '0; m_ack = 0; m_strobe = 0; m_err = 0;
            m_rword = '0; m_sword = '0; m_pword = '0;
        end else begin
            logic [2*W-1:0] seen;
            bit full, empty, bad;
            seen  = inj_en ? inj_val : m_rails;
            full  = 1; empty = 1; bad = 0;
            for (int i = 0; i < W; i++) begin
                if (seen[2*i +: 2] == 2'b00) full = 0; else empty = 0;
                if (seen[2*i +: 2] == 2'b11) bad = 1;
            end
            // sender side
            if (m_phase == 0) begin
                if (!m_ack && m_pend) begin
                    m_phase = 1; m_sword = m_pword; m_pend = snd_start;
                    if (snd_start) m_pword = snd_word;
                end else if (!m_ack && snd_start) begin
                    m_phase = 1; m_sword = snd_word;
                end else if (snd_start) begin
                    m_pend = 1; m_pword = snd_word;
                end
            end else begin
                if (m_phase == 1 && m_ack) m_phase = 2;
                else if (m_phase == 2 && !m_ack) m_phase = 0;
                if (snd_start) begin m_pend = 1; m_pword = snd_word; end
            end
            m_rails = (m_phase == 1) ? enc(m_sword) : '0;
            // receiver side
            m_strobe = 0;
            m_err = bad;
            if (!m_ack) begin
                if (full && !bad && !rcv_hold) begin
                    m_ack = 1; m_strobe = 1;
                    for (int i = 0; i < W; i++) m_rword[i] = seen[2*i+1];
                end
            end else if (empty && !rcv_hold) begin
                m_ack = 0;
            end
        end
    end

    // per-cycle comparison, scoreboard and phase order
    logic           prev_ack = 0;
    logic [2*W-1:0] prev_chan = '0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(snd_rails == m_rails, "R1/R2/R3 rails", 32'(snd_rails), 32'(m_rails));
            chk(snd_busy == m_busy(), "R4 busy", 32'(snd_busy), 32'(m_busy()));
            chk(rcv_ack == m_ack, "R5/R7/R8 ack", 32'(rcv_ack), 32'(m_ack));
            chk(rcv_strobe == m_strobe, "R6 strobe", 32'(rcv_strobe), 32'(m_strobe));
            chk(rcv_err == m_err, "R9 err", 32'(rcv_err), 32'(m_err));
            if (rcv_strobe) begin
                chk(rcv_word == m_rword, "R6 word", 32'(rcv_word), 32'(m_rword));
                if (sent_q.size() == 0) chk(0, "R11 unexpected word", 32'(rcv_word), 0);
                else begin
                    logic [W-1:0] e;
                    e = sent_q.pop_front();
                    chk(rcv_word == e, "R11 order", 32'(rcv_word), 32'(e));
                end
            end
            if (rcv_ack && !prev_ack) begin
                bit f;
                f = 1;
                for (int i = 0; i < W; i++) if (prev_chan[2*i +: 2] == 2'b00) f = 0;
                chk(f, "R5 rise on full word", 32'(prev_chan), 32'(enc(rcv_word)));
            end
            if (!rcv_ack && prev_ack)
                chk(prev_chan == '0, "R7 fall on spacer", 32'(prev_chan), 0);
        end
        prev_ack  = rcv_ack;
        prev_chan = chan;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit m_busy();
        return (m_phase != 0) || m_pend;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] w);
        snd_word = w; snd_start = 1'b1;
        sent_q.push_back(w);
        @(negedge clk);
        snd_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (snd_busy || rcv_ack) @(negedge clk);
    endtask

    initial begin
        tick(3);
        // R10 reset state
        chk(snd_rails == '0, "R10 rails", 32'(snd_rails), 0);
        chk(rcv_ack == 1'b0, "R10 ack", 32'(rcv_ack), 0);
        chk(snd_busy == 1'b0, "R10 busy", 32'(snd_busy), 0);
        chk(rcv_strobe == 1'b0 && rcv_err == 1'b0, "R10 strobe/err", 32'({rcv_strobe, rcv_err}), 0);
        rst_n = 1'b1;
        tick(1);

        // single word, step by step
        send(8'hA5);
        chk(snd_rails == 16'h9966, "R1 codeword", 32'(snd_rails), 32'h9966);
        tick(1);
        chk(rcv_ack && rcv_strobe && rcv_word == 8'hA5, "R6 capture", 32'({rcv_ack, rcv_strobe, rcv_word}), 32'h3A5);
        tick(1);
        chk(snd_rails == '0, "R2 spacer", 32'(snd_rails), 0);
        tick(1);
        chk(!rcv_ack, "R7 ack low", 32'(rcv_ack), 0);
        tick(1);
        chk(!snd_busy, "R3 idle", 32'(snd_busy), 0);

        // receiver stall
        rcv_hold = 1'b1;
        send(8'h3C);
        tick(5);
        chk(!rcv_ack && snd_rails == enc(8'h3C), "R8 held rise", 32'(rcv_ack), 0);
        rcv_hold = 1'b0;
        tick(1);
        chk(rcv_ack, "R8 rise after release", 32'(rcv_ack), 1);
        rcv_hold = 1'b1;
        tick(4);
        chk(rcv_ack, "R8 held fall", 32'(rcv_ack), 1);
        rcv_hold = 1'b0;
        wait_idle();

        // pending slot, and replacement by a later start
        send(8'h11);
        send(8'h22);
        chk(snd_busy, "R4 busy with pending", 32'(snd_busy), 1);
        wait_idle();
        tick(2);
        send(8'h44);
        snd_word = 8'h55; snd_start = 1'b1;
        @(negedge clk);
        snd_word = 8'h66;
        sent_q.push_back(8'h66);
        @(negedge clk);
        snd_start = 1'b0;
        wait_idle();
        tick(2);

        // partial words and a bad pair on the receiver input
        inj_en = 1'b1;
        inj_val = 16'h0001;
        tick(4);
        chk(!rcv_ack, "R5 partial word", 32'(rcv_ack), 0);
        inj_val = 16'h5557;
        tick(1);
        chk(rcv_err && !rcv_ack, "R9 bad pair", 32'({rcv_err, rcv_ack}), 32'h2);
        inj_val = enc(8'h0F);
        sent_q.push_back(8'h0F);
        tick(1);
        chk(!rcv_err, "R9 err clears", 32'(rcv_err), 0);
        tick(1);
        chk(rcv_ack, "R5 full word", 32'(rcv_ack), 1);
        inj_val = 16'h0100;
        tick(4);
        chk(rcv_ack, "R7 partial spacer", 32'(rcv_ack), 1);
        inj_val = '0;
        tick(2);
        chk(!rcv_ack, "R7 full spacer", 32'(rcv_ack), 0);
        inj_en = 1'b0;
        tick(2);

        // random words with random stalls
        for (int n = 0; n < 300; n++) begin
            wait_idle();
            rcv_hold = ($urandom_range(0, 3) == 0);
            send(W'($urandom));
            for (int k = 0; k < 6; k++) begin
                rcv_hold = ($urandom_range(0, 2) == 0);
                @(negedge clk);
            end
            rcv_hold = 1'b0;
        end
        wait_idle();
        tick(3);
        chk(sent_q.size() == 0, "R11 all delivered", 32'(sent_q.size()), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule